// File: doc/BRIEF.md
# Double-Buffered Input Gamma Table

This block applies a per-channel input gamma curve to pixels by direct table lookup. Each 8-bit colour component addresses a 256-entry table, and the block returns a 12-bit unsigned fraction in 0.12 format for each component. Two complete copies of the table exist, bank A and bank B. Pixels read from the active bank while the host refills the other one. Once the refill is complete, the host selects the other bank with a mode write. The selection only changes at the next frame-start pulse, so every pixel in a frame comes from the same curve.

The host loads a bank through a short register protocol. It first writes a starting entry number. It then streams values through a single data port: each write lands on the next colour of the current entry, and the entry number steps forward after the third colour. A three-bit enable selects which colours may change. A bank-select input picks the bank that receives the writes. A write aimed at the bank that is currently active is discarded and raises a sticky error flag. A status code reports which bank the pixels use.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: While reset is held and right after its release: `lut_status` is 1 (bank A active), `wr_err` is 0, `out_valid` is 0, the host entry pointer is 0 and the colour rotation points at red.
- R2: When `pix_valid` is high, then on the next clock `out_valid` is high and `out_r`/`out_g`/`out_b` carry the active bank's red, green and blue entries at addresses `pix_r`/`pix_g`/`pix_b`. When `pix_valid` is low, `out_valid` is low one clock later.
- R3: `host_idx_wr` loads the entry pointer from `host_idx_val` and restarts the rotation at red. If `host_data_wr` is high in the same cycle, the data write is dropped.
- R4: Successive `host_data_wr` pulses go to red, then green, then blue of the current entry. The entry pointer advances by one after blue and wraps from 255 to 0.
- R5: `host_wmask` bit 0 enables red, bit 1 enables green and bit 2 enables blue. A write to a disabled colour leaves the stored entry unchanged but still uses up that colour's turn in the rotation.
- R6: `host_bank_sel` = 0 sends host writes to bank A and 1 sends them to bank B. The other bank is not touched.
- R7: `mode_val` = 2 requests bank A and 3 requests bank B; other values are ignored. A request becomes active only on a cycle with `frame_start` high. A request written in that same cycle waits for the next pulse.
- R8: `lut_status` reads 1 while bank A is active and 2 while bank B is active.
- R9: A data write whose `host_bank_sel` names the active bank does not change either bank. It still advances the rotation, and it sets `wr_err`.
- R10: Once set, `wr_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idx_wr | input | 1 | Load the entry pointer |
| host_idx_val | input | 8 | New entry pointer value |
| host_data_wr | input | 1 | Sequential data write strobe |
| host_data | input | 12 | Table value (unsigned 0.12) |
| host_wmask | input | 3 | Colour write enables: bit0 red, bit1 green, bit2 blue |
| host_bank_sel | input | 1 | Host target bank: 0 = A, 1 = B |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 3 | Requested mode: 2 = bank A, 3 = bank B |
| frame_start | input | 1 | Frame boundary pulse that applies the pending mode |
| pix_valid | input | 1 | Pixel input valid |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| out_valid | output | 1 | Output valid, one clock after `pix_valid` |
| out_r | output | 12 | Red lookup result |
| out_g | output | 12 | Green lookup result |
| out_b | output | 12 | Blue lookup result |
| lut_status | output | 3 | Active bank code: 1 = A, 2 = B |
| wr_err | output | 1 | Sticky flag for a write to the active bank |

## Verification
The assertions check the following on every cycle:
- the active bank holds still except on a frame-start pulse;
- the entry pointer steps only after a blue write, and an index load restarts the rotation at red;
- no write strobe ever reaches the active bank;
- a write aimed at the active bank raises the error flag, and the flag never falls;
- output valid follows input valid one clock later.

Only the bench scenarios can show the table contents:
- that masked colours keep their old values;
- that the pointer wraps at entry 255;
- that ignored mode codes leave the active bank unchanged;
- that pixels read back exactly the values streamed into each bank.

The bench shows this by comparing every output against a behavioural model each clock.

// File: rtl/gamma_lut_pkg.sv
`timescale 1ns/1ps
package gamma_lut_pkg;
   localparam int NUM_CH = 3;

   typedef enum logic [1:0] {
      CH_R = 2'd0,
      CH_G = 2'd1,
      CH_B = 2'd2
   } chan_e;

   localparam logic [2:0] MODE_USE_A = 3'd2;
   localparam logic [2:0] MODE_USE_B = 3'd3;
   localparam logic [2:0] STAT_ON_A  = 3'd1;
   localparam logic [2:0] STAT_ON_B  = 3'd2;
endpackage

// File: rtl/lut_host_seq.sv
`timescale 1ns/1ps
module lut_host_seq
   import gamma_lut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic [IDX_W-1:0] idx_val,
   input  logic             data_wr,
   output logic [IDX_W-1:0] idx,
   output chan_e            chan,
   output logic             step
);
   // an index load wins over a data write in the same cycle
   assign step = data_wr && !idx_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         chan <= CH_R;
      end else if (idx_wr) begin
         idx  <= idx_val;
         chan <= CH_R;
      end else if (step) begin
         case (chan)
            CH_R:    chan <= CH_G;
            CH_G:    chan <= CH_B;
            default: begin
               chan <= CH_R;
               idx  <= idx + 1'b1;
            end
         endcase
      end
   end

   // R4
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && chan == CH_B) |=> (idx == $past(idx) + 1'b1 && chan == CH_R));
   // R4
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_wr && !(step && chan == CH_B)) |=> $stable(idx));
   // R3
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (idx == $past(idx_val) && chan == CH_R));
endmodule

// File: rtl/lut_swap_ctrl.sv
`timescale 1ns/1ps
module lut_swap_ctrl
   import gamma_lut_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [2:0] mode_val,
   input  logic       frame_start,
   output logic       active_b,
   output logic [2:0] status
);
   logic pending_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_b <= 1'b0;
         active_b  <= 1'b0;
      end else begin
         if (mode_wr) begin
            if (mode_val == MODE_USE_A)      pending_b <= 1'b0;
            else if (mode_val == MODE_USE_B) pending_b <= 1'b1;
         end
         if (frame_start) active_b <= pending_b;
      end
   end

   assign status = active_b ? STAT_ON_B : STAT_ON_A;

   // R7
   swap_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(active_b));
   // R7
   bad_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_val != MODE_USE_A && mode_val != MODE_USE_B) |=> $stable(pending_b));
endmodule

// File: rtl/lut_bank.sv
`timescale 1ns/1ps
module lut_bank
   import gamma_lut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 12
) (
   input  logic                           clk,
   input  logic [NUM_CH-1:0]              we,
   input  logic [IDX_W-1:0]               waddr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [NUM_CH-1:0][IDX_W-1:0]   raddr,
   output logic [NUM_CH-1:0][DATA_W-1:0]  rdata
);
   localparam int DEPTH = 1 << IDX_W;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we[c]) mem[waddr] <= wdata;
      end
      assign rdata[c] = mem[raddr[c]];
   end
endmodule

// File: rtl/gamma_pingpong_lut.sv
`timescale 1ns/1ps
module gamma_pingpong_lut
   import gamma_lut_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int DATA_W    = 12,
   parameter int OUT_STAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_idx_wr,
   input  logic [IDX_W-1:0]  host_idx_val,
   input  logic              host_data_wr,
   input  logic [DATA_W-1:0] host_data,
   input  logic [2:0]        host_wmask,
   input  logic              host_bank_sel,
   input  logic              mode_wr,
   input  logic [2:0]        mode_val,
   input  logic              frame_start,
   input  logic              pix_valid,
   input  logic [IDX_W-1:0]  pix_r,
   input  logic [IDX_W-1:0]  pix_g,
   input  logic [IDX_W-1:0]  pix_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_r,
   output logic [DATA_W-1:0] out_g,
   output logic [DATA_W-1:0] out_b,
   output logic [2:0]        lut_status,
   output logic              wr_err
);
   localparam int NBANK = 2;

   initial begin
      param_range_chk: assert (IDX_W >= 1 && IDX_W <= 12 && DATA_W >= 1 && DATA_W <= 32)
         else $error("gamma_pingpong_lut: width parameter out of range");
   end

   logic [IDX_W-1:0]                        wr_idx;
   chan_e                                   wr_chan;
   logic                                    wr_step;
   logic                                    active_b;
   logic                                    hit_active;
   logic [NUM_CH-1:0]                       chan_onehot;
   logic [NUM_CH-1:0][IDX_W-1:0]            rd_addr;
   logic [NBANK-1:0][NUM_CH-1:0]            bank_we;
   logic [NBANK-1:0][NUM_CH-1:0][DATA_W-1:0] bank_rd;
   logic [NUM_CH-1:0][DATA_W-1:0]           sel_rd;

   lut_host_seq #(.IDX_W(IDX_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (host_idx_wr),
      .idx_val (host_idx_val),
      .data_wr (host_data_wr),
      .idx     (wr_idx),
      .chan    (wr_chan),
      .step    (wr_step)
   );

   lut_swap_ctrl u_swap (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (mode_wr),
      .mode_val    (mode_val),
      .frame_start (frame_start),
      .active_b    (active_b),
      .status      (lut_status)
   );

   assign hit_active  = wr_step && (host_bank_sel == active_b);
   assign chan_onehot = 3'b001 << wr_chan;
   assign rd_addr     = {pix_b, pix_g, pix_r};

   for (genvar k = 0; k < NBANK; k++) begin : g_bank
      assign bank_we[k] = (wr_step && host_bank_sel == 1'(k) && active_b != 1'(k))
                          ? (chan_onehot & host_wmask) : '0;
      lut_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
         .clk   (clk),
         .we    (bank_we[k]),
         .waddr (wr_idx),
         .wdata (host_data),
         .raddr (rd_addr),
         .rdata (bank_rd[k])
      );
   end

   assign sel_rd = bank_rd[active_b];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wr_err <= 1'b0;
      else if (hit_active) wr_err <= 1'b1;
   end

   if (OUT_STAGE != 0) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_r     <= '0;
            out_g     <= '0;
            out_b     <= '0;
         end else begin
            out_valid <= pix_valid;
            out_r     <= sel_rd[0];
            out_g     <= sel_rd[1];
            out_b     <= sel_rd[2];
         end
      end
      // R2
      out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_valid |=> out_valid);
   end else begin : g_out_comb
      assign out_valid = pix_valid;
      assign out_r     = sel_rd[0];
      assign out_g     = sel_rd[1];
      assign out_b     = sel_rd[2];
   end

   // R9
   active_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_data_wr && !host_idx_wr && host_bank_sel == active_b) |=> wr_err);
   // R9
   no_active_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we[active_b] == '0);
   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err);
   // R8
   status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lut_status) == 1 && lut_status[2] == 1'b0);
endmodule

// File: tb/sim_gamma_pingpong_lut.sv
`timescale 1ns/1ps
module sim_gamma_pingpong_lut;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_idx_wr = 1'b0;
   logic [7:0]  host_idx_val = '0;
   logic        host_data_wr = 1'b0;
   logic [11:0] host_data = '0;
   logic [2:0]  host_wmask = 3'd7;
   logic        host_bank_sel = 1'b0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_val = '0;
   logic        frame_start = 1'b0;
   logic        pix_valid = 1'b0;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        out_valid;
   logic [11:0] out_r, out_g, out_b;
   logic [2:0]  lut_status;
   logic        wr_err;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   gamma_pingpong_lut u0 (
      .clk(clk), .rst_n(rst_n),
      .host_idx_wr(host_idx_wr), .host_idx_val(host_idx_val),
      .host_data_wr(host_data_wr), .host_data(host_data),
      .host_wmask(host_wmask), .host_bank_sel(host_bank_sel),
      .mode_wr(mode_wr), .mode_val(mode_val), .frame_start(frame_start),
      .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
      .lut_status(lut_status), .wr_err(wr_err)
   );

   function automatic int fa(int i, int c);
      return (i * 16 + c * 3 + 1) % 4096;
   endfunction
   function automatic int fb(int i, int c);
      return 4095 - ((i * 11 + c * 700) % 4096);
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int ram [2][256][3];
   bit known [2][256][3];
   int m_act, m_pend, m_idx, m_ch;
   bit m_err, m_vld, m_known, m_ok;
   int m_out [3];

   initial begin
      foreach (known[b, i, c]) known[b][i][c] = 1'b0;
      m_ok = 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_pend = 0; m_idx = 0; m_ch = 0;
         m_err = 0; m_vld = 0; m_ok = 0;
      end else begin
         m_ok  = 1;
         m_vld = pix_valid;
         if (pix_valid) begin
            m_known  = known[m_act][pix_r][0] && known[m_act][pix_g][1] && known[m_act][pix_b][2];
            m_out[0] = ram[m_act][pix_r][0];
            m_out[1] = ram[m_act][pix_g][1];
            m_out[2] = ram[m_act][pix_b][2];
         end else m_known = 0;
         if (host_idx_wr) begin
            m_idx = host_idx_val; m_ch = 0;
         end else if (host_data_wr) begin
            if (int'(host_bank_sel) == m_act) m_err = 1;
            else if (host_wmask[m_ch]) begin
               ram[host_bank_sel][m_idx][m_ch]   = host_data;
               known[host_bank_sel][m_idx][m_ch] = 1;
            end
            if (m_ch == 2) begin m_ch = 0; m_idx = (m_idx + 1) % 256; end
            else m_ch++;
         end
         if (frame_start) m_act = m_pend;
         if (mode_wr) begin
            if (mode_val == 3'd2) m_pend = 0;
            else if (mode_val == 3'd3) m_pend = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && m_ok) begin
         chk("R2 out_valid", out_valid, m_vld);
         if (m_vld && m_known) begin
            chk("R2 out_r", out_r, m_out[0]);
            chk("R2 out_g", out_g, m_out[1]);
            chk("R2 out_b", out_b, m_out[2]);
         end
         chk("R8 lut_status", lut_status, m_act ? 2 : 1);
         chk("R9 wr_err", wr_err, m_err);
      end
   end

   task automatic set_idx(int v);
      host_idx_wr = 1; host_idx_val = 8'(v);
      @(negedge clk);
      host_idx_wr = 0;
   endtask
   task automatic put(int v);
      host_data_wr = 1; host_data = 12'(v);
      @(negedge clk);
      host_data_wr = 0;
   endtask
   task automatic set_mode(int v);
      mode_wr = 1; mode_val = 3'(v);
      @(negedge clk);
      mode_wr = 0;
   endtask
   task automatic frame();
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
   endtask
   task automatic pix(int r, int g, int b);
      pix_valid = 1; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
      @(negedge clk);
      pix_valid = 0;
   endtask
   task automatic load_bank(bit sel);
      host_bank_sel = sel; host_wmask = 3'd7;
      set_idx(0);
      for (int i = 0; i < 256; i++)
         for (int c = 0; c < 3; c++)
            put(sel ? fb(i, c) : fa(i, c));
   endtask

   initial begin
      while (cycles < 50000) begin
         @(posedge clk);
         cycles++;
      end
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 status in reset", lut_status, 1);
      chk("R1 wr_err in reset", wr_err, 0);
      chk("R1 out_valid in reset", out_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 status after reset", lut_status, 1);

      // fill bank B while A is active
      load_bank(1'b1);
      set_mode(3);
      chk("R7 no swap before frame_start", lut_status, 1);
      frame();
      chk("R8 status shows bank B", lut_status, 2);
      pix(0, 255, 128);
      chk("R2 valid", out_valid, 1);
      chk("R2 red low edge", out_r, fb(0, 0));
      chk("R2 green top edge", out_g, fb(255, 1));
      chk("R2 blue mid", out_b, fb(128, 2));
      @(negedge clk);
      chk("R2 valid drops", out_valid, 0);

      // write aimed at the active bank
      host_bank_sel = 1'b1;
      set_idx(7);
      put(12'h0AB);
      chk("R9 error flag", wr_err, 1);
      pix(7, 7, 7);
      chk("R9 active bank unchanged", out_r, fb(7, 0));

      // fill bank A, switch back
      load_bank(1'b0);
      set_mode(2);
      frame();
      chk("R8 status shows bank A", lut_status, 1);
      pix(3, 200, 255);
      chk("R2 bank A red", out_r, fa(3, 0));
      chk("R2 bank A green", out_g, fa(200, 1));
      chk("R2 bank A blue", out_b, fa(255, 2));

      // masked, wrapping and restart writes into inactive bank B
      host_bank_sel = 1'b1;
      host_wmask = 3'b101;
      set_idx(10);
      put(111); put(222); put(333); put(444);
      host_wmask = 3'd7;
      set_idx(255);
      put(1); put(2); put(3); put(4);
      set_idx(20);
      put(500);
      set_idx(20);
      put(600);

      set_mode(5);
      frame();
      chk("R7 bad mode ignored", lut_status, 1);
      set_mode(3);
      frame_start = 1; mode_wr = 1; mode_val = 3'd2;
      @(negedge clk);
      frame_start = 0; mode_wr = 0;
      chk("R7 same-cycle request waits", lut_status, 2);

      pix(10, 10, 10);
      chk("R5 red written", out_r, 111);
      chk("R5 green masked", out_g, fb(10, 1));
      chk("R5 blue written", out_b, 333);
      pix(11, 0, 0);
      chk("R4 advance after blue", out_r, 444);
      pix(255, 255, 255);
      chk("R4 last entry red", out_r, 1);
      chk("R4 last entry green", out_g, 2);
      chk("R4 last entry blue", out_b, 3);
      pix(0, 0, 0);
      chk("R4 wrap to entry 0", out_r, 4);
      chk("R4 wrap green untouched", out_g, fb(0, 1));
      pix(20, 20, 20);
      chk("R3 index reload restarts at red", out_r, 600);
      chk("R3 green untouched", out_g, fb(20, 1));

      frame();
      chk("R7 pending A applied", lut_status, 1);
      pix(10, 10, 10);
      chk("R6 bank A untouched by B writes", out_r, fa(10, 0));
      chk("R10 error still set", wr_err, 1);

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule